// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit timer/counter with a single compare register and a single waveform output. It advances only on ticks from a built-in divider whose ratio comes from a 3-bit select input, so one register file can drive slow event timing and fast pulse trains alike. A 2-bit mode input picks one of four counting schemes: a plain free-running count, a count that restarts after hitting the compare value, a sawtooth pulse-width mode and a triangle (up/down) pulse-width mode.

A 2-bit output-action input decides what a compare event does to the waveform pin. Two sticky flags record counter overflow and compare hits. Each flag is cleared by writing a one to its bit and raises an interrupt line while its enable is high. A one-cycle strobe can force a compare action on the pin, in the two non-PWM modes only, without the side effects that a real match has.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, the waveform output is 0, both flags are 0 and the triangle mode starts out counting up.
- R2: A free-running 10-bit divide counter starts at 0 and advances every clock. A tick occurs when select is 1 (every clock), or when its low 3, 6, 8 or 10 bits are all ones for select 2, 3, 4 or 5 (divide by 8, 64, 256 or 1024). Select 0, 6 and 7 give no tick. The count changes only on a tick.
- R3: Mode 0 counts up by one per tick and wraps from 255 to 0. The overflow flag is set on the tick that takes the count from 255 to 0.
- R4: In mode 2, a tick that finds the count equal to the compare value loads 0. If the compare value lies below the count, the count runs on to 255 and wraps, and that 255-to-0 tick still sets the overflow flag.
- R5: Mode 3 counts 0 to 255 and wraps, setting the overflow flag on the wrap. With output action 2, a match tick drives the output low and the wrap tick drives it high. Action 3 does the reverse. When both happen on one tick, the wrap action wins.
- R6: Mode 1 counts up to 255 and holds 255 for exactly one tick, then counts down to 0. It holds 0 for one tick and counts up again. The overflow flag is set on the tick that leaves 0 while counting down. Selecting any other mode resets the direction to up.
- R7: In mode 1 with output action 2, a match tick while rising (including the tick at 255) drives the output low, and a match tick while falling drives it high. Action 3 inverts both.
- R8: In modes 0 and 2, a match tick applies the output action: 0 holds the output, 1 toggles it, 2 drives it low, 3 drives it high.
- R9: The force strobe applies the output action of R8 at the next clock edge in modes 0 and 2, with no tick needed. It sets no flag and leaves the count unchanged. In modes 1 and 3 it has no effect on the output.
- R10: Any tick on which the count equals the compare value sets the compare flag, in every mode.
- R11: Flag-clear bit 0 clears the overflow flag and bit 1 clears the compare flag. A set event in the same cycle wins over the clear.
- R12: Each interrupt output is high exactly while its flag and its enable input are both high.
- R13: In modes 1 and 3, output actions 0 and 1 leave the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Divider select (R2) |
| wave_mode | input | 2 | 0 free, 1 triangle PWM, 2 clear-on-compare, 3 sawtooth PWM |
| out_mode | input | 2 | Output action on compare |
| cmp_val | input | 8 | Compare value |
| force_cmp | input | 1 | Force-compare strobe |
| ovf_ien | input | 1 | Overflow interrupt enable |
| cmp_ien | input | 1 | Compare interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current count |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| ovf_irq | output | 1 | Overflow interrupt |
| cmp_irq | output | 1 | Compare interrupt |

## Verification
The hardest cases to reach are the ties, where one tick carries two output actions. In sawtooth mode a compare value of 255 puts the match on the wrap tick, and in triangle mode values of 0 and 255 put the match on a turning point. The stimulus sets these compare values and runs each mode through several full periods. A behavioural per-clock model is compared on every cycle, so each tie is caught on the tick where it happens. Force strobes are issued with the divider stopped, so that any change on the output can only come from the strobe. The compare value is also lowered below a running count in clear-on-compare mode, which drives the counter through its overflow wrap.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    typedef enum logic [1:0] {
        WM_FREE   = 2'd0,
        WM_DUAL   = 2'd1,
        WM_CLRCMP = 2'd2,
        WM_SAW    = 2'd3
    } wmode_e;
endpackage

// File: rtl/ptm_prescale.sv
module ptm_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] M_DIV8    = PRE_W'((1 << 3) - 1);
    localparam logic [PRE_W-1:0] M_DIV64   = PRE_W'((1 << 6) - 1);
    localparam logic [PRE_W-1:0] M_DIV256  = PRE_W'((1 << 8) - 1);
    localparam logic [PRE_W-1:0] M_DIV1024 = PRE_W'((1 << 10) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t s_d, s_q;
    logic [PRE_W-1:0] mask;
    logic             sel_on;

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
        sel_on  = 1'b1;
        case (sel)
            3'd1:    mask = '0;
            3'd2:    mask = M_DIV8;
            3'd3:    mask = M_DIV64;
            3'd4:    mask = M_DIV256;
            3'd5:    mask = M_DIV1024;
            default: begin
                mask   = '0;
                sel_on = 1'b0;
            end
        endcase
        tick = sel_on && ((s_q.pre & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ptm_count.sv
module ptm_count
    import ptm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wmode_e           mode,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             match_evt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        match_evt = tick && (s_q.cnt == cmp);
        ovf_evt   = 1'b0;
        if (mode != WM_DUAL) s_d.down = 1'b0;
        if (tick) begin
            case (mode)
                WM_FREE, WM_SAW: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    ovf_evt = (s_q.cnt == MAXV);
                end
                WM_CLRCMP: begin
                    s_d.cnt = (s_q.cnt == cmp) ? '0 : s_q.cnt + 1'b1;
                    ovf_evt = (s_q.cnt == MAXV);
                end
                default: begin
                    if (!s_q.down) begin
                        if (s_q.cnt == MAXV) begin
                            s_d.cnt  = s_q.cnt - 1'b1;
                            s_d.down = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else if (s_q.cnt == '0) begin
                        s_d.cnt  = s_q.cnt + 1'b1;
                        s_d.down = 1'b0;
                        ovf_evt  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign down = s_q.down;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cnt));
    // R3
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_FREE && s_q.cnt == MAXV) |=> (s_q.cnt == '0));
    // R4
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_CLRCMP && s_q.cnt == cmp) |=> (s_q.cnt == '0));
    // R6
    dual_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_DUAL && !s_q.down && s_q.cnt == MAXV)
        |=> (s_q.down && s_q.cnt == MAXV - 1'b1));
endmodule

// File: rtl/ptm_wave.sv
module ptm_wave
    import ptm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wmode_e     mode,
    input  logic [1:0] out_sel,
    input  logic       force_cmp,
    input  logic       down,
    input  logic       match_evt,
    input  logic       ovf_evt,
    input  logic [1:0] clr,
    input  logic       ovf_en,
    input  logic       cmp_en,
    output logic       wave,
    output logic       ovf_flag,
    output logic       cmp_flag,
    output logic       ovf_irq,
    output logic       cmp_irq
);
    typedef struct packed {
        logic wave;
        logic ovf;
        logic cmpf;
    } wave_st_t;

    wave_st_t s_d, s_q;
    logic     nonpwm;

    always_comb begin
        s_d    = s_q;
        nonpwm = (mode == WM_FREE) || (mode == WM_CLRCMP);
        if (nonpwm) begin
            if (match_evt || force_cmp) begin
                case (out_sel)
                    2'd1:    s_d.wave = ~s_q.wave;
                    2'd2:    s_d.wave = 1'b0;
                    2'd3:    s_d.wave = 1'b1;
                    default: s_d.wave = s_q.wave;
                endcase
            end
        end else if (out_sel[1]) begin
            if (mode == WM_SAW) begin
                if (ovf_evt)        s_d.wave = ~out_sel[0];
                else if (match_evt) s_d.wave = out_sel[0];
            end else if (match_evt) begin
                s_d.wave = down ? ~out_sel[0] : out_sel[0];
            end
        end
        if (clr[0])    s_d.ovf  = 1'b0;
        if (ovf_evt)   s_d.ovf  = 1'b1;
        if (clr[1])    s_d.cmpf = 1'b0;
        if (match_evt) s_d.cmpf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wave     = s_q.wave;
    assign ovf_flag = s_q.ovf;
    assign cmp_flag = s_q.cmpf;
    assign ovf_irq  = s_q.ovf & ovf_en;
    assign cmp_irq  = s_q.cmpf & cmp_en;

    // R9
    force_pwm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !nonpwm && !match_evt && !ovf_evt) |=> $stable(s_q.wave));
    // R10
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> s_q.cmpf);
    // R11
    w1c_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[1] && !match_evt) |=> !s_q.cmpf);
    // R13
    pwm_idle_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonpwm && !out_sel[1]) |=> $stable(s_q.wave));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import ptm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             force_cmp,
    input  logic             ovf_ien,
    input  logic             cmp_ien,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             wave_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             ovf_irq,
    output logic             cmp_irq
);
    wmode_e mode_e;
    logic   tick, down, match_evt, ovf_evt;

    assign mode_e = wmode_e'(wave_mode);

    ptm_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (clk_sel),
        .tick (tick)
    );

    ptm_count #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode_e),
        .cmp      (cmp_val),
        .cnt      (count),
        .down     (down),
        .match_evt(match_evt),
        .ovf_evt  (ovf_evt)
    );

    ptm_wave i_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .out_sel  (out_mode),
        .force_cmp(force_cmp),
        .down     (down),
        .match_evt(match_evt),
        .ovf_evt  (ovf_evt),
        .clr      (flag_clr),
        .ovf_en   (ovf_ien),
        .cmp_en   (cmp_ien),
        .wave     (wave_out),
        .ovf_flag (ovf_flag),
        .cmp_flag (cmp_flag),
        .ovf_irq  (ovf_irq),
        .cmp_irq  (cmp_irq)
    );
endmodule

// File: tb/test_pwm_timer8.sv
module test_pwm_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [1:0] wave_mode = '0;
    logic [1:0] out_mode = '0;
    logic [7:0] cmp_val = '0;
    logic       frc = 1'b0;
    logic       ovf_ien = 1'b0;
    logic       cmp_ien = 1'b0;
    logic [1:0] flag_clr = '0;
    logic [7:0] count;
    logic       wave_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int m_pre, m_cnt, m_dir, m_wave, m_ovf, m_cmpf;

    always #2 clk = ~clk;

    pwm_timer8 i_pwm_timer8 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
        .out_mode(out_mode), .cmp_val(cmp_val), .force_cmp(frc),
        .ovf_ien(ovf_ien), .cmp_ien(cmp_ien), .flag_clr(flag_clr),
        .count(count), .wave_out(wave_out), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
    );

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string cnt_tag(int m);
        case (m)
            0: return "R3 count";
            1: return "R6 count";
            2: return "R4 count";
            default: return "R5 count";
        endcase
    endfunction

    function automatic string wave_tag(int m);
        case (m)
            1: return "R7 wave";
            3: return "R5 wave";
            default: return "R8 wave";
        endcase
    endfunction

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin : model
        bit tick, mt, ov;
        int nc, nd, oa;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_dir = 0; m_wave = 0; m_ovf = 0; m_cmpf = 0;
        end else begin
            tick = (clk_sel == 1) || (clk_sel == 2 && m_pre % 8 == 7) ||
                   (clk_sel == 3 && m_pre % 64 == 63) ||
                   (clk_sel == 4 && m_pre % 256 == 255) ||
                   (clk_sel == 5 && m_pre % 1024 == 1023);
            mt = tick && (m_cnt == int'(cmp_val));
            ov = 1'b0;
            nc = m_cnt;
            nd = (wave_mode == 1) ? m_dir : 0;
            oa = int'(out_mode);
            if (tick) begin
                if (wave_mode == 1) begin
                    if (m_dir == 0) begin
                        if (m_cnt == 255) begin nc = 254; nd = 1; end
                        else nc = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin nc = 1; nd = 0; ov = 1'b1; end
                        else nc = m_cnt - 1;
                    end
                end else begin
                    ov = (m_cnt == 255);
                    if (wave_mode == 2 && mt) nc = 0;
                    else nc = (m_cnt + 1) % 256;
                end
            end
            if (wave_mode == 0 || wave_mode == 2) begin
                if (mt || frc) begin
                    if (oa == 1) m_wave = 1 - m_wave;
                    else if (oa == 2) m_wave = 0;
                    else if (oa == 3) m_wave = 1;
                end
            end else if (oa >= 2) begin
                if (wave_mode == 3) begin
                    if (ov) m_wave = (oa == 2) ? 1 : 0;
                    else if (mt) m_wave = (oa == 2) ? 0 : 1;
                end else if (mt) begin
                    if (m_dir == 0) m_wave = (oa == 2) ? 0 : 1;
                    else m_wave = (oa == 2) ? 1 : 0;
                end
            end
            if (flag_clr[0]) m_ovf = 0;
            if (ov) m_ovf = 1;
            if (flag_clr[1]) m_cmpf = 0;
            if (mt) m_cmpf = 1;
            m_cnt = nc;
            m_dir = nd;
            m_pre = (m_pre + 1) % 1024;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            expect_eq(cnt_tag(int'(wave_mode)), int'(count), m_cnt);
            expect_eq(wave_tag(int'(wave_mode)), int'(wave_out), m_wave);
            expect_eq("R10/R11 cmp flag", int'(cmp_flag), m_cmpf);
            expect_eq("R3/R11 ovf flag", int'(ovf_flag), m_ovf);
            expect_eq("R12 irq", int'({ovf_irq, cmp_irq}),
                      (m_ovf & int'(ovf_ien)) * 2 + (m_cmpf & int'(cmp_ien)));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_force();
        frc = 1'b1; @(negedge clk); frc = 1'b0;
    endtask

    task automatic pulse_clr(logic [1:0] b);
        flag_clr = b; @(negedge clk); flag_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin : stim
        int c0, w0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_eq("R1 count", int'(count), 0);
        expect_eq("R1 wave", int'(wave_out), 0);
        expect_eq("R1 flags", int'({ovf_flag, cmp_flag}), 0);

        // R2 divider selections
        step(20);
        expect_eq("R2 stopped", int'(count), 0);
        clk_sel = 3'd2; c0 = int'(count); step(16);
        expect_eq("R2 div8", int'(count), (c0 + 2) % 256);
        clk_sel = 3'd3; c0 = int'(count); step(128);
        expect_eq("R2 div64", int'(count), (c0 + 2) % 256);
        clk_sel = 3'd4; c0 = int'(count); step(512);
        expect_eq("R2 div256", int'(count), (c0 + 2) % 256);
        clk_sel = 3'd5; c0 = int'(count); step(1024);
        expect_eq("R2 div1024", int'(count), (c0 + 1) % 256);
        clk_sel = 3'd7; c0 = int'(count); step(40);
        expect_eq("R2 sel7", int'(count), c0);

        // R3 free mode with toggle, R12 interrupts
        wave_mode = 2'd0; out_mode = 2'd1; cmp_val = 8'd100;
        ovf_ien = 1'b1; cmp_ien = 1'b1; clk_sel = 3'd1;
        step(600);
        expect_eq("R3 ovf set", int'(ovf_flag), 1);
        expect_eq("R12 irqs", int'({ovf_irq, cmp_irq}), 3);

        // R11 clear with the divider stopped
        clk_sel = 3'd0; step(2);
        pulse_clr(2'b11);
        expect_eq("R11 cleared", int'({ovf_flag, cmp_flag}), 0);
        expect_eq("R12 irqs low", int'({ovf_irq, cmp_irq}), 0);

        // R9 force strobe in non-PWM mode
        c0 = int'(count); w0 = int'(wave_out);
        pulse_force();
        expect_eq("R9 toggle", int'(wave_out), 1 - w0);
        expect_eq("R9 no flag", int'(cmp_flag), 0);
        expect_eq("R9 count held", int'(count), c0);
        out_mode = 2'd3; pulse_force();
        expect_eq("R9 set", int'(wave_out), 1);
        out_mode = 2'd2; pulse_force();
        expect_eq("R9 clear", int'(wave_out), 0);
        out_mode = 2'd0; w0 = int'(wave_out); clk_sel = 3'd1; step(600);
        expect_eq("R8 hold action", int'(wave_out), w0);

        // R4 clear-on-compare with toggling, then compare moved below count
        wave_mode = 2'd2; out_mode = 2'd1; cmp_val = 8'd9; ovf_ien = 1'b0;
        step(200);
        clk_sel = 3'd0; step(1);
        pulse_clr(2'b01);
        cmp_val = 8'd30; clk_sel = 3'd1;
        wait (count == 8'd20); @(negedge clk);
        cmp_val = 8'd3;
        step(300);
        expect_eq("R4 wrap ovf", int'(ovf_flag), 1);
        expect_eq("R12 masked", int'(ovf_irq), 0);

        // R9 force ignored in PWM mode
        clk_sel = 3'd0; wave_mode = 2'd3; out_mode = 2'd2; step(2);
        w0 = int'(wave_out); pulse_force();
        expect_eq("R9 pwm ignore", int'(wave_out), w0);

        // R5 sawtooth, both polarities and both tie values
        clk_sel = 3'd1; cmp_val = 8'd64; step(600);
        out_mode = 2'd3; cmp_val = 8'd255; step(600);
        out_mode = 2'd2; step(600);
        expect_eq("R5 max tie high", int'(wave_out), 1);
        cmp_val = 8'd0; step(600);

        // R13 reserved action in PWM modes
        out_mode = 2'd1; w0 = int'(wave_out); step(600);
        expect_eq("R13 saw hold", int'(wave_out), w0);

        // R6 / R7 triangle mode
        wave_mode = 2'd1; out_mode = 2'd2; cmp_val = 8'd100; step(1100);
        out_mode = 2'd3; cmp_val = 8'd0; step(1100);
        out_mode = 2'd2; cmp_val = 8'd255; step(1100);
        expect_eq("R7 max match low", int'(wave_out), 0);
        out_mode = 2'd0; w0 = int'(wave_out); step(600);
        expect_eq("R13 dual hold", int'(wave_out), w0);
        clk_sel = 3'd2; out_mode = 2'd2; cmp_val = 8'd7; step(1200);

        // R6 return to up-count after mode change
        clk_sel = 3'd0; step(1);
        wave_mode = 2'd0; c0 = int'(count); clk_sel = 3'd1; step(1);
        expect_eq("R6 dir reset", int'(count), (c0 + 1) % 256);
        step(5);
        finish_run();
    end
endmodule